// File: doc/BRIEF.md
# Pulse-Width and Duty-Cycle Measurer

This block times a single phase of a digital input in whole cycles of a reference clock. A select input chooses the phase to time: the high phase or the low phase. A synchronous clear pulse starts a new measurement. The block then waits for the input to enter the chosen phase. It counts reference cycles while that phase lasts and raises a completion flag when the phase ends. The count is held until the next clear.

A host finds the duty cycle from two measurements, one with each setting of the select input. The ratio is the high count divided by the sum of the high and low counts, and the host does that division. Two edge-capture flip-flops mark the start and the end of the phase. An equivalence of their states gives both the counting-enable flag and the completion flag. One phase is therefore bracketed exactly, and later input edges have no effect.

Top module: `pulse_width_meter`

## Requirements
- R1: While `clr` is high at a rising clock edge, `width_cnt`, `count_en` and `done` are all zero one cycle later.
- R2: With `level_sel` = 1, a high phase that spans H rising edges of `clk` yields `width_cnt` = H (within ±1), so that 40/60 high/low counts give a duty cycle within 1% of 40%.
- R3: With `level_sel` = 0, a low phase that spans L rising edges yields `width_cnt` = L (within ±1).
- R4: The input passes through two synchronising flops. `count_en` rises at the third rising edge after the input enters the selected phase.
- R5: When the selected phase ends, `done` goes high and `count_en` falls. The two flags are never high together, and `width_cnt` does not change while `count_en` is low.
- R6: Once `done` is high, further input edges leave `width_cnt`, `done` and `count_en` unchanged until the next clear.
- R7: If the input is already in the selected phase when clear is released, that partial phase is not counted. The first complete phase is measured instead.
- R8: `width_cnt` saturates at all ones (2^CNT_W − 1) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; widths are counted in its cycles |
| clr | input | 1 | Synchronous clear, active high; starts a new measurement |
| level_sel | input | 1 | 1 selects the high phase, 0 the low phase; held stable during a measurement |
| sig_in | input | 1 | Asynchronous input to be measured |
| width_cnt | output | CNT_W | Measured phase width in reference cycles |
| count_en | output | 1 | High while the selected phase is being counted |
| done | output | 1 | High once the measured phase has ended |

## Verification
Some properties are checked on every cycle. These are the clearing effect of `clr` and that `count_en` and `done` are never high together. They also cover that the counter moves only under `count_en`, by exactly one until it saturates, that `done` is sticky, and that `count_en` can fall only by completing a measurement. Other behaviour only the bench scenarios can show. This covers the measured widths across a sweep of phase lengths for both levels, and the three-edge start latency. It also covers ignoring a phase already present at clear and ignoring edges after completion, plus saturation with a narrow counter.

// File: rtl/pulse_width_meter.sv
module pulse_width_meter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             level_sel,
  input  logic             sig_in,
  output logic [CNT_W-1:0] width_cnt,
  output logic             count_en,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sync1, sync2, sync3;
  logic start_q, stop_q;
  logic in_phase, was_phase, enter, leave, same;

  always_ff @(posedge clk) begin
    sync1 <= sig_in;
    sync2 <= sync1;
    sync3 <= sync2;
  end

  assign in_phase  = sync2 ~^ level_sel;
  assign was_phase = sync3 ~^ level_sel;
  assign enter     = in_phase & ~was_phase;
  assign leave     = ~in_phase & was_phase;

  always_ff @(posedge clk) begin
    if (clr) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (enter) start_q <= 1'b1;
      if (leave && start_q) stop_q <= 1'b1;
    end
  end

  assign same     = start_q ~^ stop_q;
  assign count_en = ~same;
  assign done     = same & stop_q;

  always_ff @(posedge clk) begin
    if (clr) width_cnt <= '0;
    else if (count_en && width_cnt != CNT_MAX) width_cnt <= width_cnt + 1'b1;
  end

endmodule

// File: rtl/pulse_width_meter_chk.sv
module pulse_width_meter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             clr,
  input logic [CNT_W-1:0] width_cnt,
  input logic             count_en,
  input logic             done
);

  localparam logic [CNT_W-1:0] TOP = '1;

  p_clear_zero_r1: assert property (@(posedge clk)
    $fell(clr) |-> (width_cnt == '0 && !count_en && !done));

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (clr)
    !(count_en && done));

  p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (clr)
    !count_en |=> $stable(width_cnt));

  p_step_one_r2: assert property (@(posedge clk) disable iff (clr)
    (count_en && width_cnt != TOP) |=> width_cnt == $past(width_cnt) + 1'b1);

  p_saturate_r8: assert property (@(posedge clk) disable iff (clr)
    (count_en && width_cnt == TOP) |=> width_cnt == TOP);

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (clr)
    done |=> (done && !count_en));

  p_enable_ends_in_done_r5: assert property (@(posedge clk) disable iff (clr)
    $fell(count_en) |-> done);

endmodule

bind pulse_width_meter pulse_width_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .clr(clr), .width_cnt(width_cnt), .count_en(count_en), .done(done)
);

// File: tb/pulse_width_meter_test.sv
module pulse_width_meter_test;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, clr = 1'b1, level_sel = 1'b1, sig_in = 1'b0;
  logic [W-1:0] width_cnt;
  logic count_en, done;
  int total = 0, bad = 0;
  int hi_cnt, lo_cnt;

  always #5 clk = ~clk;

  pulse_width_meter #(.CNT_W(W)) uut (
    .clk(clk), .clr(clr), .level_sel(level_sel), .sig_in(sig_in),
    .width_cnt(width_cnt), .count_en(count_en), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1'b1;
    repeat (4) @(negedge clk);
    check(width_cnt == 0 && !count_en && !done, "R1 clear", int'(width_cnt) + count_en + done, 0);
    clr = 1'b0;
  endtask

  task automatic measure(input bit sel, input int len, input string req, output int got);
    int exp;
    level_sel = sel;
    sig_in = ~sel;
    do_clear();
    repeat (4) @(negedge clk);
    sig_in = sel;
    repeat (len) @(negedge clk);
    sig_in = ~sel;
    repeat (5) @(negedge clk);
    exp = (len > MAXV) ? MAXV : len;
    got = int'(width_cnt);
    check(done && !count_en, {req, " done"}, done, 1);
    check(got >= exp - 1 && got <= exp + 1, {req, " width"}, got, exp);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int got;
    for (int n = 1; n <= 24; n++) measure(1'b1, n, "R2", got);
    for (int n = 1; n <= 24; n++) measure(1'b0, n, "R3", got);
    measure(1'b1, 100, "R2", got);
    measure(1'b0, 77, "R3", got);

    // R2 R3: duty cycle from a 40/60 pair
    measure(1'b1, 40, "R2", hi_cnt);
    measure(1'b0, 60, "R3", lo_cnt);
    check((hi_cnt * 1000) / (hi_cnt + lo_cnt) >= 390 && (hi_cnt * 1000) / (hi_cnt + lo_cnt) <= 410,
          "R2 duty permille", (hi_cnt * 1000) / (hi_cnt + lo_cnt), 400);

    // R4: enable rises at the third edge after entering the phase
    level_sel = 1'b1; sig_in = 1'b0;
    do_clear();
    repeat (4) @(negedge clk);
    sig_in = 1'b1;
    @(negedge clk) check(!count_en, "R4 edge1", count_en, 0);
    @(negedge clk) check(!count_en, "R4 edge2", count_en, 0);
    @(negedge clk) check(count_en, "R4 edge3", count_en, 1);
    repeat (3) @(negedge clk);
    sig_in = 1'b0;
    repeat (5) @(negedge clk);
    check(width_cnt == 6, "R4 width", width_cnt, 6);

    // R6: later edges ignored after done
    measure(1'b1, 8, "R6", got);
    for (int k = 1; k <= 4; k++) begin
      sig_in = ~sig_in;
      repeat (k + 3) @(negedge clk);
      check(int'(width_cnt) == got && done && !count_en, "R6 ignore", width_cnt, got);
    end

    // R7: phase already present at clear is skipped
    level_sel = 1'b1; sig_in = 1'b1;
    do_clear();
    repeat (10) @(negedge clk);
    check(width_cnt == 0 && !count_en, "R7 partial", width_cnt, 0);
    sig_in = 1'b0;
    repeat (4) @(negedge clk);
    sig_in = 1'b1;
    repeat (6) @(negedge clk);
    sig_in = 1'b0;
    repeat (5) @(negedge clk);
    check(width_cnt == 6 && done, "R7 width", width_cnt, 6);

    level_sel = 1'b0; sig_in = 1'b0;
    do_clear();
    repeat (9) @(negedge clk);
    check(width_cnt == 0 && !done, "R7 low partial", width_cnt, 0);

    // R8: saturation
    measure(1'b1, 300, "R8", got);
    check(got == MAXV, "R8 saturate", got, MAXV);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule